// File: doc/BRIEF.md
# Resolution-Enhancing Nonlinear Boxcar Filter

This block sits after a four-way time-interleaved 6-bit converter. The four slices run in round-robin order. Each slice is deliberately offset from its neighbour by a quarter of an LSB. Averaging a few neighbouring samples therefore recovers detail finer than one code step. The filter takes one code per valid input and forms the equal-weight mean of five consecutive samples centred on one sample. It then clamps that mean so the result stays within half an LSB of the centre sample. It returns the result as an unsigned fixed-point value.

The clamp is the nonlinear part. A slow or LSB-level signal gets smoothed to sub-LSB precision. A large step moves the output almost as fast as the raw codes, because the mean cannot drag the output more than half a code away from the true sample. Two side effects are accepted behaviour: a small pre-step overshoot, and partial suppression of fast, near-LSB activity.

A bypass input replaces the filtered result with the newly arriving code, with the fraction set to zero. Just after reset, the block passes the centre sample through unfiltered until its five-sample window is full.

Top module: `resboost_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_value` are cleared to 0, and the five-sample window and its fill counter are cleared; window entries reset to code 0.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. In cycles after an idle input cycle, `out_valid` is low and `out_value` holds its previous value.
- R3: `out_value` is unsigned with 6 integer bits in its upper part and 3 fraction bits in bits [2:0]. A code c with zero fraction reads as c*8.
- R4: The window holds the five most recent valid codes, and the newest arrives in the same cycle. The centre sample is the code received two valid inputs before the newest one, and each output is aligned to that centre sample.
- R5: With a full window and bypass low, the mean is floor((S*8 + 2) / 5), where S is the sum of the five codes. This is the mean rounded to nearest in eighths of an LSB.
- R6: The filtered output is the mean clamped to the range [c*8 - 4, c*8 + 4], where c is the centre code. Any larger departure is cut to the nearer bound.
- R7: For the first four valid inputs after reset, the output is the centre code times 8 with no filtering. Because the window is primed with zeros, the first two outputs are 0.
- R8: A valid input with `bypass` high gives the output in_code*8 for that sample. The window still advances, so filtering resumes on the next non-bypassed sample without a new warm-up.
- R9: A constant input code c gives an output of exactly c*8 once the window is full. The offsets of a round-robin quarter-LSB dither pattern average into intermediate fraction values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_code` for this cycle |
| in_code | input | 6 | Interleaved converter code, slices in round-robin order |
| bypass | input | 1 | Forces the output to the arriving code with zero fraction |
| out_valid | output | 1 | Qualifies `out_value`, one cycle after `in_valid` |
| out_value | output | 9 | Result, 6 integer bits and 3 fraction bits |

## Verification
The bench drives full-scale steps in both directions and one-code steps. On a full-scale step, a design without the half-LSB clamp would smear the edge across the window, and a design with the clamp sign reversed would pin the output to the wrong side of the step. The warm-up sequence after each reset tests alignment: a wrong centre tap or a wrong fill threshold shows up as a value shifted by one sample, or as filtering that starts a sample early. Constant sweeps over all 64 codes expose any rounding bias in the reciprocal divide. Quarter-LSB dither ramps and random streams with bypass and idle gaps show a wrong rounding constant, a window that stalls during bypass, or an output that changes on idle cycles.

// File: rtl/resboost_pkg.sv
package resboost_pkg;

    // Default configuration of the filter
    localparam int RB_CODE_W = 6;   // converter code width
    localparam int RB_FRAC_W = 3;   // fraction bits of the result
    localparam int RB_TAPS   = 5;   // odd boxcar length

    // Source selected for the next output value
    typedef enum logic [1:0] {
        SEL_PRIME  = 2'd0,   // window not yet full: centre passes through
        SEL_SMOOTH = 2'd1,   // clamped boxcar mean
        SEL_PASS   = 2'd2    // bypass: arriving code
    } rb_sel_e;

    typedef struct packed {
        logic    fire;       // a valid sample is accepted this cycle
        rb_sel_e sel;
    } rb_ctl_t;

    function automatic rb_sel_e rb_pick(input logic byp, input logic primed);
        if (byp)
            return SEL_PASS;
        else if (!primed)
            return SEL_PRIME;
        return SEL_SMOOTH;
    endfunction

endpackage

// File: rtl/resboost_tapline.sv
module resboost_tapline
    import resboost_pkg::*;
#(
    parameter int CODE_W = RB_CODE_W,
    parameter int TAPS   = RB_TAPS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           shift_en,
    input  logic [CODE_W-1:0]              code_in,
    output logic [TAPS-1:0][CODE_W-1:0]    taps,
    output logic                           primed
);
    localparam int DEPTH = TAPS - 1;
    localparam int CNT_W = $clog2(TAPS);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [CODE_W-1:0] hist_q [DEPTH];
    logic [CNT_W-1:0]  fill_q;

    assign taps[0] = code_in;

    genvar g;
    for (g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)
                    hist_q[g] <= '0;
                else if (shift_en)
                    hist_q[g] <= code_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)
                    hist_q[g] <= '0;
                else if (shift_en)
                    hist_q[g] <= hist_q[g-1];
            end
        end
        assign taps[g+1] = hist_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            fill_q <= '0;
        else if (shift_en && fill_q != FULL)
            fill_q <= fill_q + 1'b1;
    end

    assign primed = (fill_q == FULL);

    // R7: the fill counter saturates at the number of stored samples
    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FULL);

    // R4: an accepted code appears in the first history stage on the next cycle
    assert_shift_in_R4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (hist_q[0] == $past(code_in)));

endmodule

// File: rtl/resboost_mean.sv
module resboost_mean
    import resboost_pkg::*;
#(
    parameter int CODE_W = RB_CODE_W,
    parameter int FRAC_W = RB_FRAC_W,
    parameter int TAPS   = RB_TAPS
) (
    input  logic [TAPS-1:0][CODE_W-1:0]  taps,
    output logic [CODE_W+FRAC_W-1:0]     mean
);
    localparam int OUT_W  = CODE_W + FRAC_W;
    localparam int SUM_W  = $clog2(TAPS * ((1 << CODE_W) - 1) + 1);
    localparam int NUM_W  = SUM_W + FRAC_W + 1;
    localparam int SH     = NUM_W + $clog2(TAPS) + 1;
    localparam int PW     = NUM_W + SH + 1;
    localparam longint RECIP_L = ((longint'(1) << SH) + TAPS - 1) / TAPS;
    localparam logic [SH:0] RECIP = (SH+1)'(RECIP_L);

    logic [SUM_W-1:0] sum;
    logic [NUM_W-1:0] num;

    always_comb begin
        sum = '0;
        for (int i = 0; i < TAPS; i++)
            sum = sum + SUM_W'(taps[i]);
        // scale to eighths and add half the divisor for round-to-nearest
        num  = NUM_W'({sum, {FRAC_W{1'b0}}}) + NUM_W'(TAPS / 2);
        mean = OUT_W'((PW'(num) * PW'(RECIP)) >> SH);
    end

endmodule

// File: rtl/resboost_limit.sv
module resboost_limit
    import resboost_pkg::*;
#(
    parameter int CODE_W = RB_CODE_W,
    parameter int FRAC_W = RB_FRAC_W
) (
    input  logic [CODE_W+FRAC_W-1:0] mean,
    input  logic [CODE_W-1:0]        centre,
    output logic [CODE_W+FRAC_W-1:0] value
);
    localparam int OUT_W = CODE_W + FRAC_W;
    localparam int EXT_W = OUT_W + 1;
    localparam logic [EXT_W-1:0] HALF = EXT_W'(1) << (FRAC_W - 1);

    logic [EXT_W-1:0] base, upper, m_ext;

    always_comb begin
        base  = EXT_W'({centre, {FRAC_W{1'b0}}});
        upper = base + HALF;
        m_ext = EXT_W'(mean);
        if (m_ext > upper)
            value = OUT_W'(upper);
        else if (m_ext + HALF < base)
            value = OUT_W'(base - HALF);
        else
            value = mean;
    end

endmodule

// File: rtl/resboost_filter.sv
module resboost_filter
    import resboost_pkg::*;
#(
    parameter int CODE_W = RB_CODE_W,
    parameter int FRAC_W = RB_FRAC_W,
    parameter int TAPS   = RB_TAPS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [CODE_W-1:0]          in_code,
    input  logic                       bypass,
    output logic                       out_valid,
    output logic [CODE_W+FRAC_W-1:0]   out_value
);
    localparam int OUT_W = CODE_W + FRAC_W;
    localparam int CTR   = TAPS / 2;
    localparam int EXT_W = OUT_W + 1;
    localparam logic [EXT_W-1:0] HALF = EXT_W'(1) << (FRAC_W - 1);

    logic [TAPS-1:0][CODE_W-1:0] taps;
    logic                        primed;
    logic [OUT_W-1:0]            mean, limited, next_value;
    logic [CODE_W-1:0]           centre;
    rb_ctl_t                     ctl;

    resboost_tapline #(.CODE_W(CODE_W), .TAPS(TAPS)) u_taps (
        .clk(clk), .rst(rst), .shift_en(in_valid), .code_in(in_code),
        .taps(taps), .primed(primed)
    );

    resboost_mean #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .TAPS(TAPS)) u_mean (
        .taps(taps), .mean(mean)
    );

    assign centre = taps[CTR];

    resboost_limit #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_limit (
        .mean(mean), .centre(centre), .value(limited)
    );

    always_comb begin
        ctl.fire = in_valid;
        ctl.sel  = rb_pick(bypass, primed);
        unique case (ctl.sel)
            SEL_PASS:   next_value = {in_code, {FRAC_W{1'b0}}};
            SEL_PRIME:  next_value = {centre, {FRAC_W{1'b0}}};
            default:    next_value = limited;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_value <= '0;
        end else begin
            out_valid <= ctl.fire;
            if (ctl.fire)
                out_value <= next_value;
        end
    end

    // R2: one result per accepted sample, one cycle later
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_value)));

    // R8: bypass returns the arriving code with a zero fraction
    assert_bypass_code_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bypass) |=> (out_value == {$past(in_code), {FRAC_W{1'b0}}}));

    // R6: a non-bypassed result never strays beyond half an LSB from its centre
    assert_clamp_window_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bypass) |=>
            ((EXT_W'(out_value) + HALF >= EXT_W'({$past(centre), {FRAC_W{1'b0}}})) &&
             (EXT_W'(out_value) <= EXT_W'({$past(centre), {FRAC_W{1'b0}}}) + HALF)));

endmodule

// File: tb/resboost_filter_test.sv
module resboost_filter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [5:0] in_code = '0;
    logic       bypass = 1'b0;
    logic       out_valid;
    logic [8:0] out_value;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench model state: hist[0] newest stored code
    int hist [4];
    int seen;
    int last_out;

    always #5 clk = ~clk;

    resboost_filter uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .bypass(bypass), .out_valid(out_valid), .out_value(out_value)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) hist[i] = 0;
        seen = 0;
        last_out = 0;
    endtask

    // expected result per requirements R5..R8
    function automatic int predict(input int code, input bit byp);
        int s, m, c8;
        if (byp) return code * 8;
        c8 = hist[1] * 8;
        if (seen < 4) return c8;
        s = code + hist[0] + hist[1] + hist[2] + hist[3];
        m = (s * 8 + 2) / 5;
        if (m > c8 + 4) m = c8 + 4;
        if (m < c8 - 4) m = c8 - 4;
        return m;
    endfunction

    // called at a negedge; returns at the next negedge after checking
    task automatic send(input int code, input bit byp, input string tag);
        int exp;
        exp = predict(code, byp);
        in_valid = 1'b1;
        in_code  = 6'(code);
        bypass   = byp;
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = code;
        if (seen < 4) seen++;
        @(negedge clk);
        check({tag, " valid"}, int'(out_valid), 1);
        check(tag, int'(out_value), exp);
        last_out = exp;
    endtask

    task automatic idle();
        in_valid = 1'b0;
        bypass   = 1'b0;
        in_code  = 6'h2A;
        @(negedge clk);
        check("R2 idle valid", int'(out_valid), 0);
        check("R2 idle hold", int'(out_value), last_out);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset value", int'(out_value), 0);
    endtask

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();

        // R7 warm-up: outputs 0, 0, 20, 21, then filtered (R4 centre alignment)
        send(20, 0, "R7 warm 1");
        send(21, 0, "R7 warm 2");
        send(22, 0, "R7 warm 3");
        send(23, 0, "R7 warm 4");
        send(24, 0, "R4 first filtered");
        check("R4 centre 22", last_out, 176);
        idle();

        // R9 constant sweep over every code; R3 format c*8
        for (int c = 0; c < 64; c++)
            for (int k = 0; k < 6; k++)
                send(c, 0, "R9 constant");
        check("R3 full scale", int'(out_value), 63 * 8);

        // R5 quarter-LSB dither ramp: slice k adds k quarters before truncation
        for (int q = 160; q < 176; q++)
            for (int r = 0; r < 3; r++)
                for (int k = 0; k < 4; k++)
                    send((q + k) / 4, 0, "R5 dither");

        // R6 steps: full scale up and down, and a two-code step (preshoot bounded)
        for (int k = 0; k < 6; k++) send(0, 0, "R6 low");
        for (int k = 0; k < 6; k++) send(63, 0, "R6 step up");
        for (int k = 0; k < 6; k++) send(0, 0, "R6 step down");
        for (int k = 0; k < 6; k++) send(10, 0, "R6 base");
        for (int k = 0; k < 6; k++) send(12, 0, "R6 small step");

        // R8 bypass mid-stream, window keeps advancing
        send(30, 0, "R8 pre");
        send(50, 1, "R8 bypass");
        send(5, 1, "R8 bypass");
        send(31, 0, "R8 resume");
        send(32, 0, "R8 resume");
        idle();

        // mixed random stream with bypass and idle gaps (R2, R5, R6, R8)
        for (int n = 0; n < 3000; n++) begin
            int code;
            bit byp;
            code = int'($urandom_range(0, 63));
            byp  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 4) == 0) idle();
            send(code, byp, byp ? "R8 random" : "R6 random");
        end
        idle();

        // second reset mid-run: R1 and a fresh R7 warm-up
        do_reset();
        send(40, 0, "R7 rewarm 1");
        send(41, 0, "R7 rewarm 2");
        send(42, 0, "R7 rewarm 3");
        send(43, 0, "R7 rewarm 4");
        send(44, 0, "R7 rewarm 5");
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule